// File: doc/BRIEF.md
# Query-Based Victim Selector for an Inclusive Last-Level Cache Set

This block picks which way of one set of an inclusive last-level cache gets evicted when a miss arrives. An inclusive hierarchy has to remove any line it evicts from the core caches too. A line that is hot in a core cache looks old in the last-level cache, because hits in the core never reach it. The selector avoids throwing such a line out. Before it commits to the least-recently-used way, it asks the cores whether they still hold that line. It does this with a back-invalidate query.

If the cores answer "accept", the line is not held privately and that way becomes the victim. If they answer "reject", the line is still live in a core. The way is then moved to the most-recently-used position and the new least-recently-used way is queried. A try limit bounds the loop. When every attempt is rejected, the current least-recently-used way is evicted anyway and the result is flagged as forced. Ways that hold no valid line are used at once, without a query. The chosen way always receives the incoming tag in the most-recently-used position. A one-cycle done pulse reports the way, the number of queries used and the forced flag.

Top module: `qsel_top`

## Requirements
- R1: After reset every way is invalid, `missReady` is high, and `qryValid` and `doneValid` are low.
- R2: When a miss is accepted while some way is invalid, the lowest-numbered invalid way is chosen without any query. `doneValid` rises in the cycle after acceptance, with `doneTries` = 0 and `doneForced` = 0.
- R3: When all ways are valid, a query is raised for the least-recently-used way, and `qryTag` carries that way's stored tag.
- R4: A query stays raised with an unchanged way until `qryReady` is seen. No new query is raised while a response is pending, so only one query is ever outstanding.
- R5: An accept response (`rspAccept` = 1) makes the queried way the victim. `doneTries` then equals the number of queries sent for this miss and `doneForced` = 0.
- R6: A reject response (`rspAccept` = 0) moves the queried way to the most-recently-used position, and the next query names the new least-recently-used way.
- R7: At most MAX_TRIES queries are sent per miss. After MAX_TRIES rejects the current least-recently-used way is evicted, with `doneTries` = MAX_TRIES and `doneForced` = 1.
- R8: The victim way is written with the miss tag and becomes most-recently-used. Every way that was more recent than it ages by one position.
- R9: `missReady` is low from the acceptance of a miss until its done pulse. A `missValid` asserted during that time is ignored.
- R10: `doneValid` is high for exactly one cycle per miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| missValid | input | 1 | Miss request present |
| missTag | input | TAG_W | Tag of the missing line |
| missReady | output | 1 | Selector idle, miss taken on this edge |
| qryValid | output | 1 | Back-invalidate query raised |
| qryReady | input | 1 | Cores take the query |
| qryWay | output | WAY_W | Way being queried |
| qryTag | output | TAG_W | Tag of the queried line |
| rspValid | input | 1 | Core response present |
| rspAccept | input | 1 | 1 = line not resident in a core, 0 = resident (reject) |
| doneValid | output | 1 | Victim chosen and filled |
| doneWay | output | WAY_W | Chosen way |
| doneTries | output | TRY_W | Queries used for this miss |
| doneForced | output | 1 | Eviction forced by the try limit |

## Verification
The hardest case to reach is a forced eviction that follows a chain of rejects. Each reject reorders the recency stack, so it changes which way the next query names. The bench drives a core model from a residency bit per way and sweeps every residency mask over several rounds. These masks make the rejects land on changing stack orders and drive runs to the try limit. Random-looking ready and response delays hold queries open, so stability and single-outstanding behaviour are observed.

// File: rtl/qsel_pkg.sv
package qsel_pkg;
  typedef struct packed {
    logic fill;
    logic promote;
  } qsel_strb_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_QRY   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_EVICT = 2'd3
  } qsel_st_t;
endpackage

// File: rtl/qsel_setstate.sv
module qsel_setstate
  import qsel_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int TAG_W = 8,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qsel_strb_t       strb,
  input  logic [WAY_W-1:0] selWay,
  input  logic [TAG_W-1:0] fillTag,
  output logic [WAY_W-1:0] lruWay,
  output logic [TAG_W-1:0] lruTag,
  output logic             allValid,
  output logic [WAY_W-1:0] freeWay
);
  logic [WAY_W-1:0] rankQ [WAYS];
  logic [TAG_W-1:0] tagQ  [WAYS];
  logic [WAYS-1:0]  validQ;
  logic [WAYS-1:0]  lruVec;
  logic [WAYS-1:0]  mruVec;

  generate
    for (genvar g = 0; g < WAYS; g++) begin : g_vec
      assign lruVec[g] = (rankQ[g] == WAY_W'(WAYS - 1));
      assign mruVec[g] = (rankQ[g] == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) begin
        rankQ[i] <= WAY_W'(i);
        tagQ[i]  <= '0;
      end
      validQ <= '0;
    end else begin
      if (strb.fill || strb.promote) begin
        for (int i = 0; i < WAYS; i++) begin
          if (WAY_W'(i) == selWay) rankQ[i] <= '0;
          else if (rankQ[i] < rankQ[selWay]) rankQ[i] <= rankQ[i] + 1'b1;
        end
      end
      if (strb.fill) begin
        validQ[selWay] <= 1'b1;
        tagQ[selWay]   <= fillTag;
      end
    end
  end

  always_comb begin
    lruWay = '0;
    for (int i = 0; i < WAYS; i++)
      if (lruVec[i]) lruWay = WAY_W'(i);
  end
  assign lruTag   = tagQ[lruWay];
  assign allValid = &validQ;

  always_comb begin
    freeWay = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!validQ[i]) freeWay = WAY_W'(i);
  end

  AST_MRU_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mruVec) == 1);  // R8
  AST_LRU_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lruVec) == 1);  // R6
  AST_FILL_TO_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    strb.fill |=> mruVec[$past(selWay)]);  // R8
endmodule

// File: rtl/qsel_ctrl.sv
module qsel_ctrl
  import qsel_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int TAG_W     = 8,
  parameter int MAX_TRIES = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TRY_W = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             missValid,
  input  logic [TAG_W-1:0] missTag,
  output logic             missReady,
  output logic             qryValid,
  input  logic             qryReady,
  input  logic             rspValid,
  input  logic             rspAccept,
  input  logic [WAY_W-1:0] lruWay,
  input  logic             allValid,
  input  logic [WAY_W-1:0] freeWay,
  output qsel_strb_t       strb,
  output logic [WAY_W-1:0] selWay,
  output logic [TAG_W-1:0] fillTag,
  output logic             doneValid,
  output logic [WAY_W-1:0] doneWay,
  output logic [TRY_W-1:0] doneTries,
  output logic             doneForced
);
  qsel_st_t         stQ;
  logic [WAY_W-1:0] candWay;
  logic [TRY_W-1:0] triesQ;
  logic [TAG_W-1:0] tagR;
  logic             lastTry;

  assign missReady = (stQ == ST_IDLE);
  assign qryValid  = (stQ == ST_QRY);
  assign lastTry   = (triesQ == TRY_W'(MAX_TRIES));

  always_comb begin
    strb    = '0;
    selWay  = candWay;
    fillTag = tagR;
    case (stQ)
      ST_IDLE: if (missValid && !allValid) begin
        strb.fill = 1'b1;
        selWay    = freeWay;
        fillTag   = missTag;
      end
      ST_WAIT: if (rspValid) begin
        if (rspAccept) strb.fill = 1'b1;
        else strb.promote = 1'b1;
      end
      ST_EVICT: begin
        strb.fill = 1'b1;
        selWay    = lruWay;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stQ        <= ST_IDLE;
      candWay    <= '0;
      triesQ     <= '0;
      tagR       <= '0;
      doneValid  <= 1'b0;
      doneWay    <= '0;
      doneTries  <= '0;
      doneForced <= 1'b0;
    end else begin
      doneValid <= 1'b0;
      case (stQ)
        ST_IDLE: if (missValid) begin
          tagR   <= missTag;
          triesQ <= '0;
          if (!allValid) begin
            doneValid  <= 1'b1;
            doneWay    <= freeWay;
            doneTries  <= '0;
            doneForced <= 1'b0;
          end else begin
            stQ <= ST_QRY;
          end
        end
        ST_QRY: if (qryReady) begin
          candWay <= lruWay;
          triesQ  <= triesQ + 1'b1;
          stQ     <= ST_WAIT;
        end
        ST_WAIT: if (rspValid) begin
          if (rspAccept) begin
            doneValid  <= 1'b1;
            doneWay    <= candWay;
            doneTries  <= triesQ;
            doneForced <= 1'b0;
            stQ        <= ST_IDLE;
          end else if (lastTry) begin
            stQ <= ST_EVICT;
          end else begin
            stQ <= ST_QRY;
          end
        end
        ST_EVICT: begin
          doneValid  <= 1'b1;
          doneWay    <= lruWay;
          doneTries  <= triesQ;
          doneForced <= 1'b1;
          stQ        <= ST_IDLE;
        end
        default: stQ <= ST_IDLE;
      endcase
    end
  end

  AST_QRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    qryValid && !qryReady |=> qryValid && $stable(lruWay));  // R4
  AST_QRY_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    qryValid |-> allValid);  // R2
  AST_FORCED_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid && doneForced |-> doneTries == TRY_W'(MAX_TRIES));  // R7
  AST_TRIES_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> doneTries <= TRY_W'(MAX_TRIES));  // R5
  AST_FREE_NO_TRY: assert property (@(posedge clk) disable iff (!rst_n)
    missReady && missValid && !allValid |=> doneValid && doneTries == '0);  // R2
endmodule

// File: rtl/qsel_top.sv
module qsel_top
  import qsel_pkg::*;
#(
  parameter int WAYS      = 4,
  parameter int TAG_W     = 8,
  parameter int MAX_TRIES = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TRY_W = $clog2(MAX_TRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             missValid,
  input  logic [TAG_W-1:0] missTag,
  output logic             missReady,
  output logic             qryValid,
  input  logic             qryReady,
  output logic [WAY_W-1:0] qryWay,
  output logic [TAG_W-1:0] qryTag,
  input  logic             rspValid,
  input  logic             rspAccept,
  output logic             doneValid,
  output logic [WAY_W-1:0] doneWay,
  output logic [TRY_W-1:0] doneTries,
  output logic             doneForced
);
  qsel_strb_t       strb;
  logic [WAY_W-1:0] selWay;
  logic [TAG_W-1:0] fillTag;
  logic [WAY_W-1:0] lruWay;
  logic [TAG_W-1:0] lruTag;
  logic             allValid;
  logic [WAY_W-1:0] freeWay;

  qsel_ctrl #(.WAYS(WAYS), .TAG_W(TAG_W), .MAX_TRIES(MAX_TRIES)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .missValid(missValid), .missTag(missTag), .missReady(missReady),
    .qryValid(qryValid), .qryReady(qryReady),
    .rspValid(rspValid), .rspAccept(rspAccept),
    .lruWay(lruWay), .allValid(allValid), .freeWay(freeWay),
    .strb(strb), .selWay(selWay), .fillTag(fillTag),
    .doneValid(doneValid), .doneWay(doneWay),
    .doneTries(doneTries), .doneForced(doneForced)
  );

  qsel_setstate #(.WAYS(WAYS), .TAG_W(TAG_W)) set_i (
    .clk(clk), .rst_n(rst_n),
    .strb(strb), .selWay(selWay), .fillTag(fillTag),
    .lruWay(lruWay), .lruTag(lruTag),
    .allValid(allValid), .freeWay(freeWay)
  );

  assign qryWay = lruWay;
  assign qryTag = lruTag;
endmodule

// File: tb/qsel_top_tb_top.sv
module qsel_top_tb_top;
  localparam int WAYS  = 4;
  localparam int TAG_W = 8;
  localparam int MAXT  = 2;
  localparam int WAY_W = 2;
  localparam int TRY_W = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic missValid = 1'b0;
  logic [TAG_W-1:0] missTag = '0;
  logic missReady, qryValid, doneValid, doneForced;
  logic qryReady = 1'b0;
  logic rspValid = 1'b0;
  logic rspAccept = 1'b0;
  logic [WAY_W-1:0] qryWay, doneWay;
  logic [TAG_W-1:0] qryTag;
  logic [TRY_W-1:0] doneTries;

  int total = 0;
  int bad = 0;
  int ordr[WAYS];
  int mtag[WAYS];
  bit mval[WAYS];

  always #5 clk = ~clk;

  qsel_top #(.WAYS(WAYS), .TAG_W(TAG_W), .MAX_TRIES(MAXT)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .missValid(missValid), .missTag(missTag), .missReady(missReady),
    .qryValid(qryValid), .qryReady(qryReady), .qryWay(qryWay), .qryTag(qryTag),
    .rspValid(rspValid), .rspAccept(rspAccept),
    .doneValid(doneValid), .doneWay(doneWay),
    .doneTries(doneTries), .doneForced(doneForced)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mpromote(input int w);
    int pos = 0;
    for (int i = 0; i < WAYS; i++) if (ordr[i] == w) pos = i;
    for (int i = pos; i > 0; i--) ordr[i] = ordr[i-1];
    ordr[0] = w;
  endtask

  function automatic int mfree();
    for (int i = 0; i < WAYS; i++) if (!mval[i]) return i;
    return -1;
  endfunction

  task automatic run_miss(input int tag, input int mask, input int seed);
    int n = 0;
    bit accepted = 0;
    int accWay = 0;
    int expWay, expTries;
    bit expForced;
    bit sawDone = 0;
    int fw;
    @(negedge clk);
    missValid = 1'b1;
    missTag = TAG_W'(tag);
    @(posedge clk); #1;
    missValid = 1'b0;
    for (int k = 0; k < 12 && !sawDone; k++) begin
      int waitc = 0;
      @(negedge clk);
      while (!qryValid && !doneValid && waitc < 40) begin
        @(negedge clk);
        waitc++;
      end
      if (waitc >= 40) begin
        chk(0, "R10 watchdog", 0, 1);
        return;
      end
      if (doneValid) begin
        sawDone = 1;
      end else begin
        int w;
        int d;
        n++;
        w = ordr[WAYS-1];
        chk(n <= MAXT, "R7 query count", n, MAXT);
        chk(mfree() < 0, "R2 query with invalid way", mfree(), -1);
        chk(int'(qryWay) == w, "R3/R6 query way", int'(qryWay), w);
        chk(int'(qryTag) == mtag[w], "R3 query tag", int'(qryTag), mtag[w]);
        if (n == 1) begin
          missValid = 1'b1;
          missTag = TAG_W'(8'hEE);
          chk(missReady == 1'b0, "R9 busy missReady", int'(missReady), 0);
        end
        d = (seed + n * 3) % 4;
        for (int j = 0; j < d; j++) begin
          @(negedge clk);
          chk(qryValid && int'(qryWay) == w, "R4 query held", int'(qryWay), w);
        end
        qryReady = 1'b1;
        @(posedge clk); #1;
        qryReady = 1'b0;
        missValid = 1'b0;
        d = (seed + n) % 3;
        for (int j = 0; j < d; j++) begin
          @(negedge clk);
          chk(!qryValid && !doneValid, "R4 single outstanding", int'(qryValid), 0);
        end
        @(negedge clk);
        rspValid = 1'b1;
        rspAccept = !mask[w];
        @(posedge clk); #1;
        rspValid = 1'b0;
        if (!mask[w]) begin
          accepted = 1;
          accWay = w;
        end else begin
          mpromote(w);
        end
      end
    end
    fw = mfree();
    if (fw >= 0) begin
      expWay = fw; expTries = 0; expForced = 0;
    end else if (accepted) begin
      expWay = accWay; expTries = n; expForced = 0;
    end else begin
      expWay = ordr[WAYS-1]; expTries = MAXT; expForced = 1;
      chk(n == MAXT, "R7 tries before force", n, MAXT);
    end
    chk(int'(doneWay) == expWay, fw >= 0 ? "R2 victim way" : "R5/R7 victim way", int'(doneWay), expWay);
    chk(int'(doneTries) == expTries, "R5 tries", int'(doneTries), expTries);
    chk(doneForced == expForced, "R7 forced flag", int'(doneForced), int'(expForced));
    mval[expWay] = 1;
    mtag[expWay] = tag;
    mpromote(expWay);
    @(negedge clk);
    chk(!doneValid, "R10 done pulse width", int'(doneValid), 0);
    chk(missReady, "R9 ready after done", int'(missReady), 1);
  endtask

  initial begin
    for (int i = 0; i < WAYS; i++) begin
      ordr[i] = i; mtag[i] = 0; mval[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(missReady, "R1 reset missReady", int'(missReady), 1);
    chk(!qryValid, "R1 reset qryValid", int'(qryValid), 0);
    chk(!doneValid, "R1 reset doneValid", int'(doneValid), 0);
    for (int i = 0; i < WAYS; i++) run_miss(16 + i, 0, i);
    for (int r = 0; r < 3; r++)
      for (int m = 0; m < 16; m++)
        run_miss(32 + r * 16 + m, (m + r * 5) % 16, m + r);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule